// File: doc/BRIEF.md
# Variable Step Wrapping Counter

This block is a W-bit count register whose step size and direction are chosen on every cycle. A signed step arrives on its own input; when the advance enable is high, that step is added to the count. The sum is taken modulo two to the power of W, so a positive step runs past the top of the range into low values. A negative step runs below zero into the top of the range.

Two further controls override stepping. A synchronous clear returns the count to its parameterised start value. A load enable replaces the count with a supplied value. The output is the register itself, so every change appears one clock after the inputs that caused it.

Top module: `step_ctr`

## Requirements
- R1: While `rst` is high at a clock edge, the count becomes `INIT_VAL`. With the defaults this is 0x3C, and `count_q` shows it after that edge.
- R2: When `adv_en` is high and neither `clr_req` nor `ld_en` is high, the count after the edge equals the old count plus the step, modulo 2^CNT_W. With positive steps the count rises.
- R3: A negative step, given in two's complement on `step_val`, makes the count fall. Passing below zero wraps to the top of the range. For example, 0x02 with a step of -5 gives 0xFD.
- R4: A positive step that passes the top of the range wraps to low values. For example, 0xFA with a step of +7 gives 0x01.
- R5: When `clr_req` is high, the count becomes `INIT_VAL`. This holds whatever the values of `ld_en` and `adv_en` are.
- R6: When `ld_en` is high and `clr_req` is low, the count becomes `ld_val`. This holds even if `adv_en` is high.
- R7: When `adv_en`, `ld_en` and `clr_req` are all low, the count holds. The values on `step_val` and `ld_val` have no effect.
- R8: `step_val` is STEP_W bits wide, 5 by default, and is treated as signed. It is sign-extended to CNT_W bits before the add. So 5'b10000 means -16 and 5'b01111 means +15.
- R9: `count_q` is driven straight from the register. A change caused by the inputs of one cycle appears on `count_q` one cycle later, and no sooner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Advance the count by the step |
| step_val | input | STEP_W | Signed step, two's complement |
| clr_req | input | 1 | Return the count to INIT_VAL (highest priority) |
| ld_en | input | 1 | Load `ld_val` into the count |
| ld_val | input | CNT_W | Value to load |
| count_q | output | CNT_W | Registered count |

## Verification
All later values are offsets from the present count. A wrong register value therefore shows on `count_q` on the very next cycle. After that it persists through every step and hold, shifted by the same amount, until a clear or a load writes an absolute value. A sign-extension fault shows only when the step's top bit is set. For this reason the tests include the most negative step and the largest positive step, and wraps in both directions.

// File: rtl/step_ctr_pkg.sv
package step_ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2,
    OP_CLR  = 2'd3
  } ctr_op_t;
endpackage

// File: rtl/step_ctr_decode.sv
module step_ctr_decode
  import step_ctr_pkg::*;
(
  input  logic    adv_en,
  input  logic    clr_req,
  input  logic    ld_en,
  output ctr_op_t op
);
  // Fixed priority: clear, then load, then step.
  always_comb begin
    if (clr_req)     op = OP_CLR;
    else if (ld_en)  op = OP_LOAD;
    else if (adv_en) op = OP_STEP;
    else             op = OP_HOLD;
  end
endmodule

// File: rtl/step_ctr_ext.sv
module step_ctr_ext #(
  parameter int CNT_W  = 8,
  parameter int STEP_W = 5
) (
  input  logic [STEP_W-1:0] step_val,
  output logic [CNT_W-1:0]  step_ext
);
  localparam int PAD_W = (CNT_W > STEP_W) ? CNT_W - STEP_W : 1;

  generate
    if (STEP_W >= CNT_W) begin : g_trunc
      // The upper bits drop out of a modular sum anyway.
      assign step_ext = step_val[CNT_W-1:0];
    end else begin : g_sext
      logic [PAD_W-1:0] pad;
      assign pad      = {PAD_W{step_val[STEP_W-1]}};
      assign step_ext = {pad, step_val};
    end
  endgenerate
endmodule

// File: rtl/step_ctr.sv
module step_ctr
  import step_ctr_pkg::*;
#(
  parameter int              CNT_W    = 8,
  parameter int              STEP_W   = 5,
  parameter logic [CNT_W-1:0] INIT_VAL = 8'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_en,
  input  logic [STEP_W-1:0] step_val,
  input  logic              clr_req,
  input  logic              ld_en,
  input  logic [CNT_W-1:0]  ld_val,
  output logic [CNT_W-1:0]  count_q
);
  ctr_op_t          op;
  logic [CNT_W-1:0] step_ext;
  logic [CNT_W-1:0] cnt_r;
  logic [CNT_W-1:0] cnt_nxt;

  step_ctr_decode u_decode (
    .adv_en  (adv_en),
    .clr_req (clr_req),
    .ld_en   (ld_en),
    .op      (op)
  );

  step_ctr_ext #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_ext (
    .step_val (step_val),
    .step_ext (step_ext)
  );

  always_comb begin
    unique case (op)
      OP_CLR:  cnt_nxt = INIT_VAL;
      OP_LOAD: cnt_nxt = ld_val;
      OP_STEP: cnt_nxt = cnt_r + step_ext;
      default: cnt_nxt = cnt_r;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_r <= INIT_VAL;
    else     cnt_r <= cnt_nxt;
  end

  assign count_q = cnt_r;

  // R1
  reset_value_chk: assert property (@(posedge clk)
    $past(rst) |-> count_q == INIT_VAL);

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> count_q == INIT_VAL);

  // R6
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_en && !clr_req) |=> count_q == $past(ld_val));

  // R2 R3 R4 R8
  step_delta_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !ld_en && !clr_req) |=> (count_q - $past(count_q)) == $past(step_ext));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv_en && !ld_en && !clr_req) |=> $stable(count_q));
endmodule

// File: tb/test_step_ctr.sv
`timescale 1ns/1ps
module test_step_ctr;
  localparam int CNT_W  = 8;
  localparam int STEP_W = 5;
  localparam logic [CNT_W-1:0] INIT_VAL = 8'h3C;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              adv_en = 1'b0;
  logic [STEP_W-1:0] step_val = '0;
  logic              clr_req = 1'b0;
  logic              ld_en = 1'b0;
  logic [CNT_W-1:0]  ld_val = '0;
  logic [CNT_W-1:0]  count_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  step_ctr #(.CNT_W(CNT_W), .STEP_W(STEP_W), .INIT_VAL(INIT_VAL)) i_step_ctr (
    .clk(clk), .rst(rst), .adv_en(adv_en), .step_val(step_val),
    .clr_req(clr_req), .ld_en(ld_en), .ld_val(ld_val), .count_q(count_q)
  );

  task automatic chk(input string req, input logic [CNT_W-1:0] exp);
    n_chk++;
    if (count_q !== exp) begin
      n_bad++;
      $display("FAIL %s: count_q=%h expected %h", req, count_q, exp);
    end
  endtask

  // Drive one cycle of inputs, then sample just after the edge.
  task automatic cyc(input logic a, input logic [STEP_W-1:0] s,
                     input logic c, input logic l, input logic [CNT_W-1:0] v);
    @(negedge clk);
    adv_en = a; step_val = s; clr_req = c; ld_en = l; ld_val = v;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1", INIT_VAL);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_up();
    cyc(1'b1, 5'd3, 1'b0, 1'b0, 8'h00);
    chk("R2", 8'h3F);
    cyc(1'b1, 5'd15, 1'b0, 1'b0, 8'h00);
    chk("R2", 8'h4E);
  endtask

  task automatic t_latency();
    cyc(1'b0, 5'd0, 1'b0, 1'b1, 8'hA5);
    @(negedge clk);
    ld_en = 1'b1; ld_val = 8'h11;
    #1;
    chk("R9", 8'hA5); // not yet visible before the edge
    @(posedge clk); #1;
    chk("R9", 8'h11);
  endtask

  task automatic t_up_wrap();
    cyc(1'b0, 5'd0, 1'b0, 1'b1, 8'hFA);
    chk("R6", 8'hFA);
    cyc(1'b1, 5'd7, 1'b0, 1'b0, 8'h00);
    chk("R4", 8'h01);
  endtask

  task automatic t_down_wrap();
    cyc(1'b0, 5'd0, 1'b0, 1'b1, 8'h02);
    cyc(1'b1, 5'b11011, 1'b0, 1'b0, 8'h00);
    chk("R3", 8'hFD);
    cyc(1'b1, 5'b11111, 1'b0, 1'b0, 8'h00);
    chk("R3", 8'hFC);
  endtask

  task automatic t_sext();
    cyc(1'b0, 5'd0, 1'b0, 1'b1, 8'h10);
    cyc(1'b1, 5'b10000, 1'b0, 1'b0, 8'h00);
    chk("R8", 8'h00);
    cyc(1'b1, 5'b01111, 1'b0, 1'b0, 8'h00);
    chk("R8", 8'h0F);
  endtask

  task automatic t_priority();
    cyc(1'b1, 5'd4, 1'b0, 1'b1, 8'h77);
    chk("R6", 8'h77);
    cyc(1'b1, 5'd4, 1'b1, 1'b1, 8'h99);
    chk("R5", INIT_VAL);
    cyc(1'b1, 5'd1, 1'b0, 1'b0, 8'h00);
    cyc(1'b0, 5'd0, 1'b1, 1'b0, 8'h00);
    chk("R5", INIT_VAL);
  endtask

  task automatic t_hold();
    cyc(1'b0, 5'd0, 1'b0, 1'b1, 8'h5A);
    cyc(1'b0, 5'd7, 1'b0, 1'b0, 8'hC3);
    chk("R7", 8'h5A);
    cyc(1'b0, 5'b10101, 1'b0, 1'b0, 8'h0F);
    chk("R7", 8'h5A);
  endtask

  initial begin
    t_reset();
    t_up();
    t_latency();
    t_up_wrap();
    t_down_wrap();
    t_sext();
    t_priority();
    t_hold();
    t_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule